// File: doc/BRIEF.md
# Codec Register Access Port

This block lets a host reach the control registers of up to two external audio codecs through one 32-bit register. The host writes that register one byte at a time. The two low bytes hold a 16-bit data word. The third byte holds a command: a read/write flag and a 7-bit codec register index. The top byte holds the codec select bit and a status field. Toward the codecs the block drives a simple bus. It raises a request with an index, a direction and write data, then waits for an acknowledge that returns read data.

A transaction starts when the host writes the command byte. The block issues even indices to the selected codec. It handles odd indices locally: an odd read returns zero, and an odd write is dropped. A busy flag is visible to the host while a request is outstanding. When a read completes, the block sets a sticky valid flag that belongs to the codec that answered. The block also keeps a shadow copy of the last value moved to or from each codec and presents it on an output port.

The control is a two-state machine. `ST_IDLE` waits for a command. On the `LAUNCH` transition, taken when an even-index command is written to a present codec, it moves to `ST_WAIT`. `ST_WAIT` holds the request until the codec acknowledges, and the `FINISH` transition then returns it to `ST_IDLE`.

Top module: `acp_codec_port`

## Requirements
- R1: After reset, all 32 bits of the host register read zero, no codec request is raised, and both shadow copies are zero.
- R2: A host write to byte 0 or byte 1 stores the low or high half of the data word. A host write to byte 3 stores bits 7:6 only, and bits 5:0 keep their previous contents.
- R3: Writing byte 2 with bit 7 clear and an even index in bits 6:0 sends a codec request with cdc_wr=1. The request carries that index, cdc_sel equal to byte 3 bit 6, and the current data word. On acknowledge, the shadow copy of that codec takes the data word, and the other codec's shadow copy is unchanged.
- R4: Writing byte 2 with bit 7 set and an even index sends a codec request with cdc_wr=0. On acknowledge, cdc_rdata is loaded into the data word and into the shadow copy of that codec. The valid flag of that codec is set: byte 3 bit 1 for codec 0 and byte 3 bit 3 for codec 1.
- R5: A read command with an odd index raises no request. In the following cycle the data word is 0x0000 and the selected codec's valid flag is set.
- R6: A write command with an odd index raises no request and changes neither the data word nor any shadow copy.
- R7: Byte 3 bit 0 is the busy flag. It is 1 from the edge that launches a request until the edge on which the acknowledge is taken. A byte 2 write made while busy is ignored: no request is issued and byte 2 keeps its value.
- R8: When the cdc_present bit of the selected codec is 0, a command raises no request, leaves the data word unchanged and sets no valid flag.
- R9: Valid flags stay set until reset, and a host write to byte 3 does not clear them. Byte 3 bits 2, 4 and 5 always read 0.
- R10: While a request is outstanding, cdc_req stays high until cdc_ack. cdc_idx, cdc_sel, cdc_wr and cdc_wdata stay stable for the whole request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host byte write strobe |
| host_byte | input | 2 | Byte lane selected by the host write |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 32 | Full host register contents |
| cdc_present | input | 2 | Per-codec presence, bit n for codec n |
| cdc_req | output | 1 | Codec request, held until acknowledge |
| cdc_wr | output | 1 | 1 = write, 0 = read |
| cdc_sel | output | 1 | Target codec number |
| cdc_idx | output | 7 | Codec register index (always even) |
| cdc_wdata | output | 16 | Write data sent to the codec |
| cdc_ack | input | 1 | Codec acknowledge, one-cycle pulse |
| cdc_rdata | input | 16 | Read data, valid with cdc_ack |
| shadow_flat | output | 32 | Shadow copies; codec n occupies bits 16n+15:16n |

## Verification
The bench builds the block with its default widths: a 7-bit index, a 16-bit data word and two codecs. Both codecs are therefore real targets, so the bench can observe the two valid-flag positions and the separation between the two shadow copies. A behavioural codec acknowledges three cycles after each request. That latency leaves several cycles in which the bench checks the busy flag and tries a command that must be ignored. Toggling presence, alternating codec selection and mixing odd and even indices covers the local completion paths as well as the bus path.

// File: rtl/acp_pkg.sv
package acp_pkg;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = 7;
    localparam int DATA_W    = 16;
    localparam int NUM_CODEC = 2;
    localparam int SEL_W     = 1;
    localparam int REG_W     = 4 * BYTE_W;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } acp_state_e;

    typedef struct packed {
        logic               wr;
        logic [SEL_W-1:0]   sel;
        logic [IDX_W-1:0]   idx;
        logic [DATA_W-1:0]  wdata;
    } acp_issue_t;
endpackage

// File: rtl/acp_ctrl_fsm.sv
module acp_ctrl_fsm
    import acp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic       ack,
    output acp_state_e state,
    output logic       req,
    output logic       idle
);
    acp_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (launch) nxt = ST_WAIT;   // LAUNCH
            ST_WAIT: if (ack)    nxt = ST_IDLE;   // FINISH
        endcase
    end

    always_comb begin
        req  = 1'b0;
        idle = 1'b0;
        unique case (state)
            ST_IDLE: idle = 1'b1;
            ST_WAIT: req  = 1'b1;
        endcase
    end
endmodule

// File: rtl/acp_shadow.sv
module acp_shadow #(
    parameter int NUM   = 2,
    parameter int W     = 16,
    localparam int SW   = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [SW-1:0]  sel,
    input  logic [W-1:0]   wdata,
    output logic [NUM*W-1:0] flat
);
    for (genvar c = 0; c < NUM; c++) begin : g_copy
        logic [W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                             val_q <= '0;
            else if (we && (sel == SW'(c)))         val_q <= wdata;
        end
        assign flat[c*W +: W] = val_q;
    end
endmodule

// File: rtl/acp_codec_port.sv
module acp_codec_port
    import acp_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_we,
    input  logic [1:0]              host_byte,
    input  logic [BYTE_W-1:0]       host_wdata,
    output logic [REG_W-1:0]        host_rdata,
    input  logic [NUM_CODEC-1:0]    cdc_present,
    output logic                    cdc_req,
    output logic                    cdc_wr,
    output logic [SEL_W-1:0]        cdc_sel,
    output logic [IDX_W-1:0]        cdc_idx,
    output logic [DATA_W-1:0]       cdc_wdata,
    input  logic                    cdc_ack,
    input  logic [DATA_W-1:0]       cdc_rdata,
    output logic [NUM_CODEC*DATA_W-1:0] shadow_flat
);
    localparam logic [1:0] LANE_LO  = 2'd0;
    localparam logic [1:0] LANE_HI  = 2'd1;
    localparam logic [1:0] LANE_CMD = 2'd2;
    localparam logic [1:0] LANE_CTL = 2'd3;

    logic [DATA_W-1:0]    data_q;
    logic [BYTE_W-1:0]    cmd_q;
    logic [1:0]           ctl_q;
    logic [NUM_CODEC-1:0] valid_q;
    acp_issue_t           issue_q;

    acp_state_e state;
    logic       idle;
    logic       busy;

    logic       cmd_take, is_rd, is_odd, tgt_here, launch, odd_rd, done;
    logic [SEL_W-1:0] tgt_sel;

    assign tgt_sel  = ctl_q[0];
    assign is_rd    = host_wdata[BYTE_W-1];
    assign is_odd   = host_wdata[0];
    assign tgt_here = cdc_present[tgt_sel];
    assign cmd_take = host_we && (host_byte == LANE_CMD) && idle;
    assign launch   = cmd_take && tgt_here && !is_odd;
    assign odd_rd   = cmd_take && tgt_here && is_odd && is_rd;
    assign done     = busy && cdc_ack;

    acp_ctrl_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .ack    (cdc_ack),
        .state  (state),
        .req    (busy),
        .idle   (idle)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            cmd_q   <= '0;
            ctl_q   <= '0;
            valid_q <= '0;
            issue_q <= '0;
        end else begin
            if (done && !issue_q.wr)
                data_q <= cdc_rdata;
            else if (odd_rd)
                data_q <= '0;
            else if (host_we && host_byte == LANE_LO)
                data_q[BYTE_W-1:0] <= host_wdata;
            else if (host_we && host_byte == LANE_HI)
                data_q[DATA_W-1:BYTE_W] <= host_wdata;

            if (cmd_take)
                cmd_q <= host_wdata;
            if (host_we && host_byte == LANE_CTL)
                ctl_q <= host_wdata[BYTE_W-1:BYTE_W-2];

            if (launch) begin
                issue_q.wr    <= !is_rd;
                issue_q.sel   <= tgt_sel;
                issue_q.idx   <= host_wdata[IDX_W-1:0];
                issue_q.wdata <= data_q;
            end

            for (int c = 0; c < NUM_CODEC; c++) begin
                if ((done && !issue_q.wr && issue_q.sel == SEL_W'(c)) ||
                    (odd_rd && tgt_sel == SEL_W'(c)))
                    valid_q[c] <= 1'b1;
            end
        end
    end

    acp_shadow #(.NUM(NUM_CODEC), .W(DATA_W)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (done),
        .sel   (issue_q.sel),
        .wdata (issue_q.wr ? issue_q.wdata : cdc_rdata),
        .flat  (shadow_flat)
    );

    assign cdc_req   = (state == ST_WAIT);
    assign cdc_wr    = issue_q.wr;
    assign cdc_sel   = issue_q.sel;
    assign cdc_idx   = issue_q.idx;
    assign cdc_wdata = issue_q.wdata;

    assign host_rdata = {ctl_q, 2'b00, valid_q[1], 1'b0, valid_q[0], busy,
                         cmd_q, data_q};
endmodule

// File: rtl/acp_codec_port_chk.sv
module acp_codec_port_chk
    import acp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  host_rdata,
    input logic              cdc_req,
    input logic              cdc_ack,
    input logic              cdc_wr,
    input logic [SEL_W-1:0]  cdc_sel,
    input logic [IDX_W-1:0]  cdc_idx,
    input logic [DATA_W-1:0] cdc_wdata
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cdc_req && !cdc_ack |=> cdc_req); // R10

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cdc_req && $past(cdc_req) |-> $stable(cdc_idx) && $stable(cdc_sel) &&
        $stable(cdc_wr) && $stable(cdc_wdata)); // R10

    AST_EVEN_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        cdc_req |-> !cdc_idx[0]); // R6

    AST_ACK_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cdc_req && cdc_ack |=> !host_rdata[24]); // R7

    AST_VALID0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[25] |=> host_rdata[25]); // R9

    AST_VALID1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[27] |=> host_rdata[27]); // R9

    AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rdata[26] && !host_rdata[28] && !host_rdata[29]); // R9

    AST_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cdc_req) && cdc_wr |-> cdc_wdata == host_rdata[15:0]); // R3
endmodule

bind acp_codec_port acp_codec_port_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_rdata (host_rdata),
    .cdc_req    (cdc_req),
    .cdc_ack    (cdc_ack),
    .cdc_wr     (cdc_wr),
    .cdc_sel    (cdc_sel),
    .cdc_idx    (cdc_idx),
    .cdc_wdata  (cdc_wdata)
);

// File: tb/acp_codec_port_tb_top.sv
module acp_codec_port_tb_top;
    import acp_pkg::*;

    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_byte = '0;
    logic [7:0]  host_wdata = '0;
    logic [31:0] host_rdata;
    logic [1:0]  cdc_present = 2'b11;
    logic        cdc_req, cdc_wr;
    logic [0:0]  cdc_sel;
    logic [6:0]  cdc_idx;
    logic [15:0] cdc_wdata;
    logic        cdc_ack = 1'b0;
    logic [15:0] cdc_rdata = '0;
    logic [31:0] shadow_flat;

    always #2 clk = ~clk;

    acp_codec_port dut_i (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_byte(host_byte),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cdc_present(cdc_present), .cdc_req(cdc_req), .cdc_wr(cdc_wr),
        .cdc_sel(cdc_sel), .cdc_idx(cdc_idx), .cdc_wdata(cdc_wdata),
        .cdc_ack(cdc_ack), .cdc_rdata(cdc_rdata), .shadow_flat(shadow_flat)
    );

    typedef struct packed {
        logic        wr;
        logic        sel;
        logic [6:0]  idx;
        logic [15:0] wdata;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    bit   ended = 0;

    function automatic logic [15:0] mdl(input logic s, input logic [6:0] i);
        return {s ? 8'hC1 : 8'h3A, 1'b0, i};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wr_byte(input logic [1:0] b, input logic [7:0] v);
        @(negedge clk);
        host_we = 1'b1; host_byte = b; host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (host_rdata[24]) @(negedge clk);
    endtask

    // codec model: acknowledges LAT cycles after a request appears
    int cnt = 0;
    always @(negedge clk) begin
        if (cdc_ack) begin
            cdc_ack = 1'b0;
            cnt = 0;
        end else if (cdc_req) begin
            cnt++;
            if (cnt == LAT) begin
                cdc_ack = 1'b1;
                cdc_rdata = mdl(cdc_sel, cdc_idx);
            end
        end else begin
            cnt = 0;
        end
    end

    // scoreboard monitor: each new request is compared with the queue head
    bit   seen = 0;
    exp_t cur;
    always @(negedge clk) begin
        if (rst_n && cdc_req && !seen) begin
            seen = 1;
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R7 unexpected request actual=%h expected=none",
                         {cdc_wr, cdc_sel, cdc_idx});
            end else begin
                cur = exp_q.pop_front();
                check("R3_R4 request", {23'd0, cdc_wr, cdc_sel, cdc_idx},
                      {23'd0, cur.wr, cur.sel, cur.idx});
                if (cur.wr)
                    check("R3 wdata", {16'd0, cdc_wdata}, {16'd0, cur.wdata});
            end
        end
        if (!cdc_req) seen = 0;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 register", host_rdata, 32'h0);
        check("R1 shadow", shadow_flat, 32'h0);
        check("R1 req", {31'd0, cdc_req}, 32'd0);

        wr_byte(2'd0, 8'h34);
        wr_byte(2'd1, 8'h12);
        check("R2 data", {16'd0, host_rdata[15:0]}, 32'h1234);
        wr_byte(2'd3, 8'hFF);
        check("R2 byte3", {24'd0, host_rdata[31:24]}, 32'hC0);
        wr_byte(2'd3, 8'h00);

        exp_q.push_back('{wr:1'b1, sel:1'b0, idx:7'h04, wdata:16'h1234});
        wr_byte(2'd2, 8'h04);
        check("R7 busy set", {31'd0, host_rdata[24]}, 32'd1);
        wr_byte(2'd2, 8'h86);
        check("R7 cmd ignored", {24'd0, host_rdata[23:16]}, 32'h04);
        wait_idle();
        @(negedge clk);
        check("R3 shadow0", {16'd0, shadow_flat[15:0]}, 32'h1234);

        exp_q.push_back('{wr:1'b0, sel:1'b0, idx:7'h10, wdata:16'h0});
        wr_byte(2'd2, 8'h90);
        wait_idle();
        @(negedge clk);
        check("R4 data", {16'd0, host_rdata[15:0]}, {16'd0, mdl(1'b0, 7'h10)});
        check("R4 shadow0", {16'd0, shadow_flat[15:0]}, {16'd0, mdl(1'b0, 7'h10)});
        check("R4 valid0", {24'd0, host_rdata[31:24]}, 32'h02);

        cdc_present = 2'b01;
        wr_byte(2'd3, 8'h40);
        check("R9 byte3 keeps flag", {24'd0, host_rdata[31:24]}, 32'h42);
        wr_byte(2'd0, 8'h77);
        wr_byte(2'd1, 8'h77);
        wr_byte(2'd2, 8'h88);
        @(negedge clk);
        check("R8 data kept", {16'd0, host_rdata[15:0]}, 32'h7777);
        check("R8 no valid", {24'd0, host_rdata[31:24]}, 32'h42);
        check("R8 no req", {31'd0, cdc_req}, 32'd0);

        cdc_present = 2'b11;
        wr_byte(2'd2, 8'h83);
        check("R5 data zero", {16'd0, host_rdata[15:0]}, 32'h0);
        check("R5 valid1", {24'd0, host_rdata[31:24]}, 32'h4A);
        check("R5 no req", {31'd0, cdc_req}, 32'd0);

        exp_q.push_back('{wr:1'b0, sel:1'b1, idx:7'h20, wdata:16'h0});
        wr_byte(2'd2, 8'hA0);
        wait_idle();
        @(negedge clk);
        check("R4 data1", {16'd0, host_rdata[15:0]}, {16'd0, mdl(1'b1, 7'h20)});
        check("R4 shadow1", {16'd0, shadow_flat[31:16]}, {16'd0, mdl(1'b1, 7'h20)});

        wr_byte(2'd0, 8'h55);
        wr_byte(2'd1, 8'h55);
        wr_byte(2'd2, 8'h05);
        check("R6 no req", {31'd0, cdc_req}, 32'd0);
        @(negedge clk);
        check("R6 data kept", {16'd0, host_rdata[15:0]}, 32'h5555);
        check("R6 shadow kept", shadow_flat, {mdl(1'b1, 7'h20), mdl(1'b0, 7'h10)});

        wr_byte(2'd0, 8'hEF);
        wr_byte(2'd1, 8'hBE);
        exp_q.push_back('{wr:1'b1, sel:1'b1, idx:7'h0A, wdata:16'hBEEF});
        wr_byte(2'd2, 8'h0A);
        wait_idle();
        @(negedge clk);
        check("R3 shadow1", {16'd0, shadow_flat[31:16]}, 32'hBEEF);
        check("R3 shadow0 untouched", {16'd0, shadow_flat[15:0]}, {16'd0, mdl(1'b0, 7'h10)});

        wr_byte(2'd3, 8'h00);
        check("R9 sticky flags", {24'd0, host_rdata[31:24]}, 32'h0A);
        check("R3_R4 queue drained", exp_q.size(), 0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule